// File: doc/BRIEF.md
# Dual-Source Buffer Address Counter

This block holds the address pointer of a pixel buffer memory that is written from a camera-side source and read back by a slower USB-side reader. Every register in the counting path is clocked by the fast pixel clock only. A direction input chooses between fill and drain. In fill mode the pointer steps up on each pixel-clock edge where the line and frame valid inputs are both low. In drain mode the pointer steps down once for each rising edge of an asynchronous read strobe.

The read strobe is brought into the pixel domain through a chain of synchronizer flops. An edge-tracking state machine then turns each rising edge into a single-cycle decrement pulse. Its states are `SE_PRIME`, `SE_LOW` and `SE_HIGH`:
- After reset it starts in `SE_PRIME`. It goes to `SE_HIGH` if the synchronized level is high and to `SE_LOW` otherwise, and it emits no pulse while doing so.
- `SE_LOW` goes to `SE_HIGH` on a high level and emits the pulse during that cycle.
- `SE_HIGH` returns to `SE_LOW` on a low level.

The counter core chooses one action per cycle with a case on the mode: `ACT_INC`, `ACT_DEC` or `ACT_HOLD`. The two active-low reset inputs are combined, so either one can reset the block. Reset asserts asynchronously and is released through a two-flop synchronizer.

Top module: `pixbuf_addr_counter`

## Requirements
- R1: While either reset input is low, `buf_addr` is 0, and it clears at once when a reset input falls.
- R2: After both reset inputs go high, the counter stays at 0 through the first two pixel-clock rising edges and can change first on the third.
- R3: When `drain_mode` is 0 and `line_vld` and `frame_vld` are both 0 at a rising edge, `buf_addr` increases by 1 at that edge.
- R4: When `drain_mode` is 0 and `line_vld` or `frame_vld` is 1 at a rising edge, `buf_addr` is unchanged at that edge.
- R5: When `drain_mode` is 1, each rising edge of `rd_stb` lowers `buf_addr` by exactly 1. The change appears at the third pixel-clock edge after the strobe rises. The strobe must stay high and low for at least two pixel-clock periods each.
- R6: A falling edge of `rd_stb`, or a strobe held high for many cycles, causes no further change.
- R7: The count wraps modulo 2^22: decrementing 0 gives 0x3FFFFF, and incrementing 0x3FFFFF gives 0.
- R8: Strobe edges have no effect in fill mode, and the valid inputs have no effect in drain mode.
- R9: A change of `drain_mode` alone does not change `buf_addr`.
- R10: A strobe that is already high when reset is released causes no decrement. Only a later rising edge counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pix | input | 1 | Pixel clock, the only clock of the block |
| rst_a_n | input | 1 | Active-low reset, first source |
| rst_b_n | input | 1 | Active-low reset, second source |
| drain_mode | input | 1 | 0 = fill (count up), 1 = drain (count down) |
| line_vld | input | 1 | Line valid; qualifies increments when low |
| frame_vld | input | 1 | Frame valid; qualifies increments when low |
| rd_stb | input | 1 | Asynchronous read strobe from the reader domain |
| buf_addr | output | 22 | Buffer address pointer |

## Verification
The hardest cases to reach are the wrap at the top of the 22-bit range and a strobe that is already high when reset is released. Walking the counter up to 0x3FFFFF would take four million cycles. The bench gets there from reset instead: one strobe edge in drain mode takes 0 to 0x3FFFFF, and one qualified fill cycle then takes it back to 0. For the second case, the bench raises the strobe while both reset inputs are low and keeps it high through the release. It checks that nothing counts until a fresh low-to-high transition arrives. Every strobe test waits three edges before sampling, to allow for the synchronizer latency.

// File: rtl/pixbuf_pkg.sv
package pixbuf_pkg;

    typedef enum logic [1:0] {
        SE_PRIME = 2'd0,
        SE_LOW   = 2'd1,
        SE_HIGH  = 2'd2
    } strobe_state_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_DEC  = 2'd2
    } count_act_t;

    typedef enum logic {
        MODE_FILL  = 1'b0,
        MODE_DRAIN = 1'b1
    } dir_mode_t;

endpackage

// File: rtl/pixbuf_rst_sync.sv
module pixbuf_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic raw_rst_n,
    output logic sync_rst_n
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge raw_rst_n) begin
                if (!raw_rst_n) chain_q <= '0;
                else            chain_q <= 1'b1;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge raw_rst_n) begin
                if (!raw_rst_n) chain_q <= '0;
                else            chain_q <= {chain_q[LAST-1:0], 1'b1};
            end
        end
    endgenerate

    assign sync_rst_n = chain_q[LAST];

    // The release may only follow a clock edge at which the raw reset was already inactive.
    assert_release_synced_R2: assert property (@(posedge clk)
        $rose(sync_rst_n) |-> $past(raw_rst_n));

endmodule

// File: rtl/pixbuf_strobe_edge.sv
module pixbuf_strobe_edge
    import pixbuf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic rise_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0]  sync_q;
    logic           level;
    strobe_state_t  state_q, state_d;

    // Synchronizer chain: no reset, so it is already settled when reset is released.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) sync_q <= strobe_async;
        end else begin : g_chain
            always_ff @(posedge clk) sync_q <= {sync_q[LAST-1:0], strobe_async};
        end
    endgenerate

    assign level = sync_q[LAST];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SE_PRIME;
        else        state_q <= state_d;
    end

    // Next state and output
    always_comb begin
        state_d    = state_q;
        rise_pulse = 1'b0;
        unique case (state_q)
            SE_PRIME: state_d = level ? SE_HIGH : SE_LOW;
            SE_LOW: begin
                if (level) begin
                    state_d    = SE_HIGH;
                    rise_pulse = 1'b1;
                end
            end
            SE_HIGH: if (!level) state_d = SE_LOW;
            default: state_d = SE_PRIME;
        endcase
    end

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

    assert_no_pulse_after_prime_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SE_PRIME) |-> !rise_pulse);

endmodule

// File: rtl/pixbuf_count_core.sv
module pixbuf_count_core
    import pixbuf_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dir_mode_t         mode,
    input  logic              fill_qual,
    input  logic              dec_pulse,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    count_act_t        act;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        act = ACT_HOLD;
        unique case (mode)
            MODE_FILL:  act = fill_qual ? ACT_INC : ACT_HOLD;
            MODE_DRAIN: act = dec_pulse ? ACT_DEC : ACT_HOLD;
            default:    act = ACT_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            unique case (act)
                ACT_INC:  addr_q <= addr_q + ONE;
                ACT_DEC:  addr_q <= addr_q - ONE;
                ACT_HOLD: addr_q <= addr_q;
                default:  addr_q <= addr_q;
            endcase
        end
    end

    assign addr = addr_q;

    assert_clear_in_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (addr_q == '0));

    assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FILL && fill_qual) |=> (addr_q == $past(addr_q) + ONE));

    assert_drain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DRAIN && dec_pulse) |=> (addr_q == $past(addr_q) - ONE));

    assert_cross_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_FILL && !fill_qual) || (mode == MODE_DRAIN && !dec_pulse))
        |=> $stable(addr_q));

endmodule

// File: rtl/pixbuf_addr_counter.sv
module pixbuf_addr_counter
    import pixbuf_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int RST_STAGES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_pix,
    input  logic              rst_a_n,
    input  logic              rst_b_n,
    input  logic              drain_mode,
    input  logic              line_vld,
    input  logic              frame_vld,
    input  logic              rd_stb,
    output logic [ADDR_W-1:0] buf_addr
);
    logic      raw_rst_n;
    logic      rst_n;
    logic      dec_pulse;
    logic      fill_qual;
    dir_mode_t mode;

    // Either source asserted means reset.
    assign raw_rst_n = rst_a_n & rst_b_n;
    assign fill_qual = !line_vld && !frame_vld;
    assign mode      = drain_mode ? MODE_DRAIN : MODE_FILL;

    pixbuf_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
        .clk        (clk_pix),
        .raw_rst_n  (raw_rst_n),
        .sync_rst_n (rst_n)
    );

    pixbuf_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) strobe_i (
        .clk          (clk_pix),
        .rst_n        (rst_n),
        .strobe_async (rd_stb),
        .rise_pulse   (dec_pulse)
    );

    pixbuf_count_core #(.ADDR_W(ADDR_W)) core_i (
        .clk       (clk_pix),
        .rst_n     (rst_n),
        .mode      (mode),
        .fill_qual (fill_qual),
        .dec_pulse (dec_pulse),
        .addr      (buf_addr)
    );

    assert_dir_alone_R9: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (drain_mode != $past(drain_mode) && !dec_pulse && drain_mode) |=> $stable(buf_addr));

endmodule

// File: tb/pixbuf_addr_counter_tb.sv
module pixbuf_addr_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    logic clk_pix = 1'b0;
    logic rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic drain_mode = 1'b0, line_vld = 1'b1, frame_vld = 1'b1, rd_stb = 1'b0;
    logic [AW-1:0] buf_addr;
    logic [AW-1:0] exp_addr;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk_pix = ~clk_pix;

    pixbuf_addr_counter dut_i (
        .clk_pix(clk_pix), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
        .drain_mode(drain_mode), .line_vld(line_vld), .frame_vld(frame_vld),
        .rd_stb(rd_stb), .buf_addr(buf_addr)
    );

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_checks++;
        if (buf_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: buf_addr=%h expected=%h at %0t", req, buf_addr, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk_pix);
        @(negedge clk_pix);
    endtask

    task automatic quiet_reset();
        rst_a_n = 1'b0; rst_b_n = 1'b0;
        line_vld = 1'b1; frame_vld = 1'b1; rd_stb = 1'b0;
        tick(3);
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        tick(4);
        exp_addr = '0;
    endtask

    task automatic t_reset();
        drain_mode = 1'b0; line_vld = 1'b0; frame_vld = 1'b0;
        tick(4);
        check("R1 held in reset", '0);
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        tick(1);
        check("R2 first edge after release", '0);
        tick(1);
        check("R2 second edge after release", '0);
        tick(1);
        check("R2 third edge counts", AW'(1));
        tick(3);
        check("R3 continued count", AW'(4));
        #1 rst_b_n = 1'b0;
        #1 check("R1 async clear by rst_b_n", '0);
        tick(2);
        rst_b_n = 1'b1;
        tick(5);
        rst_a_n = 1'b0;
        #1 check("R1 async clear by rst_a_n", '0);
        tick(1);
        rst_a_n = 1'b1;
        tick(1);
    endtask

    task automatic t_fill();
        quiet_reset();
        drain_mode = 1'b0;
        line_vld = 1'b0; frame_vld = 1'b0;
        tick(10); exp_addr += 10;
        check("R3 fill ten cycles", exp_addr);
        line_vld = 1'b1; frame_vld = 1'b0; tick(5);
        check("R4 line valid blocks", exp_addr);
        line_vld = 1'b0; frame_vld = 1'b1; tick(5);
        check("R4 frame valid blocks", exp_addr);
        line_vld = 1'b1; frame_vld = 1'b1; tick(5);
        check("R4 both valid block", exp_addr);
        for (int i = 0; i < 8; i++) begin
            line_vld = i[0]; frame_vld = 1'b0;
            tick(1);
        end
        exp_addr += 4;
        check("R3 alternating qualifier", exp_addr);
    endtask

    task automatic t_drain();
        line_vld = 1'b1; frame_vld = 1'b1;
        drain_mode = 1'b1;
        tick(3);
        check("R9 direction change alone", exp_addr);
        line_vld = 1'b0; frame_vld = 1'b0;
        tick(6);
        check("R8 qualifier ignored in drain", exp_addr);
        rd_stb = 1'b1;
        tick(2);
        check("R5 before latency", exp_addr);
        tick(1); exp_addr -= 1;
        check("R5 single decrement", exp_addr);
        tick(8);
        check("R6 long high level", exp_addr);
        rd_stb = 1'b0;
        tick(5);
        check("R6 falling edge", exp_addr);
        for (int i = 0; i < 5; i++) begin
            rd_stb = 1'b1; tick(2);
            rd_stb = 1'b0; tick(2);
        end
        tick(3); exp_addr -= 5;
        check("R5 minimum width strobes", exp_addr);
        drain_mode = 1'b0; line_vld = 1'b1; frame_vld = 1'b1;
        tick(2);
        check("R9 back to fill", exp_addr);
        rd_stb = 1'b1; tick(4);
        rd_stb = 1'b0; tick(4);
        check("R8 strobe ignored in fill", exp_addr);
    endtask

    task automatic t_wrap();
        quiet_reset();
        drain_mode = 1'b1;
        tick(2);
        rd_stb = 1'b1; tick(4);
        rd_stb = 1'b0; tick(3);
        check("R7 wrap below zero", TOP);
        drain_mode = 1'b0; line_vld = 1'b0; frame_vld = 1'b0;
        tick(1);
        line_vld = 1'b1; frame_vld = 1'b1;
        tick(1);
        check("R7 wrap above top", '0);
    endtask

    task automatic t_stb_at_release();
        rst_a_n = 1'b0; rst_b_n = 1'b0;
        drain_mode = 1'b1; line_vld = 1'b1; frame_vld = 1'b1;
        rd_stb = 1'b1;
        tick(4);
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        tick(8);
        check("R10 high strobe at release", '0);
        rd_stb = 1'b0; tick(4);
        check("R10 after fall", '0);
        rd_stb = 1'b1; tick(4);
        check("R10 fresh edge counts", TOP);
        rd_stb = 1'b0; tick(3);
    endtask

    initial begin
        exp_addr = '0;
        @(negedge clk_pix);
        check("R1 reset state", '0);
        t_reset();
        t_fill();
        t_drain();
        t_wrap();
        t_stb_at_release();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule